// File: doc/BRIEF.md
# Register-Mapped SPI Master Serial Port

This block is a byte-wide SPI master controlled through a small 32-bit register bus. Software enables the receiver and transmitter with write-one command bits and programs the clock divider and the mode word (master code, clock polarity, clock phase, loopback, clock output enable, wait-for-read). It then writes characters into a transmit holding register. Each character moves into a shift register, goes out MSB first on MOSI while MISO is sampled, and lands in a receive holding register that software reads.

Status flags for receive-ready, transmit-ready and overrun share one bit layout with an interrupt mask. The mask is set through one address and cleared through another. The interrupt output is the OR of the flags that are both set and unmasked. Chip select is handled outside the block. The bus is a plain register interface rather than a stream: a write lands in the cycle its strobe is sampled, read data is combinational from the address, and a read strobe only has a side effect on the receive holding register. Back-pressure is handled through the transmit-ready and receive-ready flags, which software polls or takes as interrupts.

Top module: `spi_port_master`

## Requirements
- R1: After reset the status register (0x14) reads 0, the mode register (0x04) reads 0, the divider (0x20) reads 6, irq_o is 0 and sck_o is 0.
- R2: A write to the command register (0x00) acts only on the bits set to 1. Bit 4 enables and bit 5 disables the receiver, and bit 6 enables and bit 7 disables the transmitter. Disable wins when both bits are set. Bit 2 resets the receiver, clearing receive-ready and overrun. Bit 3 resets the transmitter, dropping any byte waiting in the holding register. Transmit-ready (status bit 1) reads 1 only while the transmitter is enabled and its holding register is empty.
- R3: The mode register keeps only bits 3:0, 7:6, 8, 15, 16, 18 and 20, so writing all ones reads back 0x001581CF. No character starts shifting unless bits 3:0 hold 0xE.
- R4: A write to the divider register (0x20) stores the value clamped to the range 6 to 65536, and that value reads back. One SCK period lasts that many bus clock cycles.
- R5: Characters go out MSB first and come in MSB first. Mode bit 16 sets the SCK idle level. With mode bit 8 at 0, data is sampled on the leading SCK edge; with bit 8 at 1, it is sampled on the trailing edge.
- R6: With mode bit 15 set, the receiver takes the outgoing MOSI data instead of MISO, so the received byte equals the sent byte.
- R7: A write to the transmit holding register (0x1C) clears transmit-ready. Transmit-ready sets again once the byte moves into the shift register. A write while the transmitter is disabled is ignored.
- R8: A completed character is stored in the receive holding register (0x18) and sets receive-ready (status bit 0). Reading 0x18 clears receive-ready.
- R9: A character that completes while receive-ready is still set raises overrun (status bit 5) and overwrites the holding register with the newer byte. Overrun stays set until a receiver reset.
- R10: With mode bit 20 set, a byte waiting in the transmit holding register does not start until receive-ready is clear.
- R11: Writing a 1 to a bit of 0x08 sets that mask bit and writing a 1 to 0x0C clears it, for status bits 0, 1 and 5. irq_o is high exactly when a set status bit is also unmasked.
- R12: The read-only register at 0xFC returns the VERSION parameter (default 0x00000103).
- R13: With mode bit 18 clear, characters still shift (for example in loopback) but sck_o stays at the idle level with no edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and shift clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 8 | Register byte address |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rd_i | input | 1 | Read strobe (clears receive-ready on 0x18) |
| bus_rdata_o | output | 32 | Combinational read data |
| irq_o | output | 1 | Level interrupt |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
The bench acts as an SPI slave in all four polarity and phase combinations and checks that bytes move both ways. A design with the edges swapped, or with the bit order reversed, would return a shifted or mirrored byte. The bench also goes after the divider clamp at both ends. Clamp logic written the wrong way round would give SCK periods shorter than six cycles, or a value that wraps. It drives two characters back to back with no read in between. A design that cleared overrun on a read, or kept the older byte, would show the wrong status or data. Wait-for-read mode is checked by showing that the second byte stays held, and writes with the transmitter disabled or with the master code missing are checked to move nothing.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int OFF_CMD  = 'h00;
  localparam int OFF_MODE = 'h04;
  localparam int OFF_IEN  = 'h08;
  localparam int OFF_IDIS = 'h0C;
  localparam int OFF_STAT = 'h14;
  localparam int OFF_RHR  = 'h18;
  localparam int OFF_THR  = 'h1C;
  localparam int OFF_DIV  = 'h20;
  localparam int OFF_VER  = 'hFC;

  localparam int CMD_RX_RST = 2;
  localparam int CMD_TX_RST = 3;
  localparam int CMD_RX_ON  = 4;
  localparam int CMD_RX_OFF = 5;
  localparam int CMD_TX_ON  = 6;
  localparam int CMD_TX_OFF = 7;

  localparam logic [3:0] MASTER_CODE = 4'hE;
  localparam int MD_PHASE  = 8;
  localparam int MD_LOOP   = 15;
  localparam int MD_POL    = 16;
  localparam int MD_CKOUT  = 18;
  localparam int MD_WAITRD = 20;
  localparam logic [31:0] MODE_KEEP = 32'h0015_81CF;

  localparam int ST_RXRDY = 0;
  localparam int ST_TXRDY = 1;
  localparam int ST_OVR   = 5;
  localparam logic [31:0] IRQ_KEEP = 32'h0000_0023;
endpackage

// File: rtl/spi_div_clamp.sv
module spi_div_clamp #(
  parameter int DIV_W   = 17,
  parameter int DIV_MIN = 6,
  parameter int DIV_MAX = 65536
) (
  input  logic [DIV_W-1:0] raw_i,
  output logic [DIV_W-1:0] div_o
);
  localparam logic [DIV_W-1:0] LO = DIV_W'(DIV_MIN);
  localparam logic [DIV_W-1:0] HI = DIV_W'(DIV_MAX);

  always_comb begin
    if (raw_i < LO)      div_o = LO;
    else if (raw_i > HI) div_o = HI;
    else                 div_o = raw_i;
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int CHAR_W = 8,
  parameter int DIV_W  = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CHAR_W-1:0] data_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              ckout_i,
  input  logic              loop_i,
  input  logic              abort_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [CHAR_W-1:0] rx_o,
  output logic              sck_o,
  output logic              mosi_o
);
  localparam int BIT_W = (CHAR_W > 1) ? $clog2(CHAR_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(CHAR_W - 1);

  logic [DIV_W-1:0]  div_l, cnt;
  logic              half;
  logic [BIT_W-1:0]  bitn;
  logic [CHAR_W-1:0] tx_sh, rx_sh;
  logic [DIV_W-1:0]  h0_len, h1_len;
  logic              rx_in;

  // first half of each bit: data valid; second half: after sample point
  assign h0_len = div_l >> 1;
  assign h1_len = div_l - h0_len;
  assign rx_in  = loop_i ? tx_sh[CHAR_W-1] : miso_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      div_l  <= '0;
      cnt    <= '0;
      half   <= 1'b0;
      bitn   <= '0;
      tx_sh  <= '0;
      rx_sh  <= '0;
    end else begin
      done_o <= 1'b0;
      if (abort_i) begin
        busy_o <= 1'b0;
      end else if (start_i && !busy_o) begin
        busy_o <= 1'b1;
        div_l  <= div_i;
        cnt    <= (div_i >> 1) - 1'b1;
        half   <= 1'b0;
        bitn   <= '0;
        tx_sh  <= data_i;
      end else if (busy_o) begin
        if (cnt != '0) begin
          cnt <= cnt - 1'b1;
        end else if (!half) begin
          rx_sh <= {rx_sh[CHAR_W-2:0], rx_in};
          half  <= 1'b1;
          cnt   <= h1_len - 1'b1;
        end else if (bitn == LAST_BIT) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end else begin
          bitn  <= bitn + 1'b1;
          tx_sh <= {tx_sh[CHAR_W-2:0], 1'b0};
          half  <= 1'b0;
          cnt   <= h0_len - 1'b1;
        end
      end
    end
  end

  assign sck_o  = cpol_i ^ (ckout_i & busy_o & (half ^ cpha_i));
  assign mosi_o = tx_sh[CHAR_W-1];
  assign rx_o   = rx_sh;
endmodule

// File: rtl/spi_rx_hold.sv
module spi_rx_hold #(
  parameter int CHAR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic              rx_en_i,
  input  logic [CHAR_W-1:0] data_i,
  input  logic              rd_i,
  input  logic              clr_i,
  output logic [CHAR_W-1:0] rhr_o,
  output logic              rdy_o,
  output logic              ovr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rhr_o <= '0;
      rdy_o <= 1'b0;
      ovr_o <= 1'b0;
    end else if (clr_i) begin
      rhr_o <= '0;
      rdy_o <= 1'b0;
      ovr_o <= 1'b0;
    end else if (done_i && rx_en_i) begin
      rhr_o <= data_i;
      rdy_o <= 1'b1;
      if (rdy_o && !rd_i) ovr_o <= 1'b1;
    end else if (rd_i) begin
      rdy_o <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_port_master.sv
module spi_port_master
  import spi_port_pkg::*;
#(
  parameter int          ADDR_W  = 8,
  parameter int          CHAR_W  = 8,
  parameter int          DIV_W   = 17,
  parameter int          DIV_MIN = 6,
  parameter int          DIV_MAX = 65536,
  parameter logic [31:0] VERSION = 32'h0000_0103
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [31:0]       bus_wdata_i,
  input  logic              bus_rd_i,
  output logic [31:0]       bus_rdata_o,
  output logic              irq_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i
);
  logic [31:0]       mode_q, imask_q, status;
  logic [DIV_W-1:0]  div_q, div_clamped;
  logic              rx_en_q, tx_en_q;
  logic [CHAR_W-1:0] thr_q, rhr, eng_rx;
  logic              thr_full_q;
  logic              wr_cmd, wr_mode, wr_ien, wr_idis, wr_thr, wr_div, rd_rhr;
  logic              rx_rst, tx_rst, wr_thr_ok;
  logic              eng_busy, eng_done, tx_start, rxrdy, ovr, txrdy;
  logic              master_ok, waitrd;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int off);
    return a == ADDR_W'(off);
  endfunction

  assign wr_cmd  = bus_wr_i && hit(bus_addr_i, OFF_CMD);
  assign wr_mode = bus_wr_i && hit(bus_addr_i, OFF_MODE);
  assign wr_ien  = bus_wr_i && hit(bus_addr_i, OFF_IEN);
  assign wr_idis = bus_wr_i && hit(bus_addr_i, OFF_IDIS);
  assign wr_thr  = bus_wr_i && hit(bus_addr_i, OFF_THR);
  assign wr_div  = bus_wr_i && hit(bus_addr_i, OFF_DIV);
  assign rd_rhr  = bus_rd_i && hit(bus_addr_i, OFF_RHR);

  assign rx_rst    = wr_cmd && bus_wdata_i[CMD_RX_RST];
  assign tx_rst    = wr_cmd && bus_wdata_i[CMD_TX_RST];
  assign wr_thr_ok = wr_thr && tx_en_q;

  assign master_ok = (mode_q[3:0] == MASTER_CODE);
  assign waitrd    = mode_q[MD_WAITRD];
  assign tx_start  = thr_full_q && tx_en_q && !eng_busy && master_ok &&
                     !(waitrd && rxrdy) && !tx_rst;
  assign txrdy     = tx_en_q && !thr_full_q;

  spi_div_clamp #(.DIV_W(DIV_W), .DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX)) u_clamp (
    .raw_i (bus_wdata_i[DIV_W-1:0]),
    .div_o (div_clamped)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= '0;
      imask_q    <= '0;
      div_q      <= DIV_W'(DIV_MIN);
      rx_en_q    <= 1'b0;
      tx_en_q    <= 1'b0;
      thr_q      <= '0;
      thr_full_q <= 1'b0;
    end else begin
      if (wr_mode) mode_q <= bus_wdata_i & MODE_KEEP;
      if (wr_div)  div_q  <= div_clamped;
      if (wr_ien)       imask_q <= imask_q | (bus_wdata_i & IRQ_KEEP);
      else if (wr_idis) imask_q <= imask_q & ~bus_wdata_i;
      if (wr_cmd) begin
        if (bus_wdata_i[CMD_RX_OFF])     rx_en_q <= 1'b0;
        else if (bus_wdata_i[CMD_RX_ON]) rx_en_q <= 1'b1;
        if (bus_wdata_i[CMD_TX_OFF])     tx_en_q <= 1'b0;
        else if (bus_wdata_i[CMD_TX_ON]) tx_en_q <= 1'b1;
      end
      if (tx_rst) begin
        thr_full_q <= 1'b0;
      end else if (wr_thr_ok) begin
        thr_q      <= bus_wdata_i[CHAR_W-1:0];
        thr_full_q <= 1'b1;
      end else if (tx_start) begin
        thr_full_q <= 1'b0;
      end
    end
  end

  spi_shift_engine #(.CHAR_W(CHAR_W), .DIV_W(DIV_W)) u_engine (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (tx_start),
    .data_i  (thr_q),
    .div_i   (div_q),
    .cpol_i  (mode_q[MD_POL]),
    .cpha_i  (mode_q[MD_PHASE]),
    .ckout_i (mode_q[MD_CKOUT]),
    .loop_i  (mode_q[MD_LOOP]),
    .abort_i (tx_rst),
    .miso_i  (miso_i),
    .busy_o  (eng_busy),
    .done_o  (eng_done),
    .rx_o    (eng_rx),
    .sck_o   (sck_o),
    .mosi_o  (mosi_o)
  );

  spi_rx_hold #(.CHAR_W(CHAR_W)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .done_i  (eng_done),
    .rx_en_i (rx_en_q),
    .data_i  (eng_rx),
    .rd_i    (rd_rhr),
    .clr_i   (rx_rst),
    .rhr_o   (rhr),
    .rdy_o   (rxrdy),
    .ovr_o   (ovr)
  );

  always_comb begin
    status = '0;
    status[ST_RXRDY] = rxrdy;
    status[ST_TXRDY] = txrdy;
    status[ST_OVR]   = ovr;
  end

  assign irq_o = |(status & imask_q);

  always_comb begin
    bus_rdata_o = '0;
    if (hit(bus_addr_i, OFF_MODE))      bus_rdata_o = mode_q;
    else if (hit(bus_addr_i, OFF_STAT)) bus_rdata_o = status;
    else if (hit(bus_addr_i, OFF_RHR))  bus_rdata_o = 32'(rhr);
    else if (hit(bus_addr_i, OFF_DIV))  bus_rdata_o = 32'(div_q);
    else if (hit(bus_addr_i, OFF_VER))  bus_rdata_o = VERSION;
  end
endmodule

// File: rtl/spi_port_checker.sv
module spi_port_checker (
  input logic clk,
  input logic rst_n,
  input logic sck,
  input logic cpol,
  input logic busy,
  input logic ovr,
  input logic rx_rst,
  input logic rd_rhr,
  input logic done,
  input logic rxrdy,
  input logic waitrd,
  input logic start,
  input logic wr_thr_ok,
  input logic txrdy
);
  assert_sck_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck == cpol);

  assert_ovr_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovr && !rx_rst |=> ovr);

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rhr && !done && !rx_rst |=> !rxrdy);

  assert_wait_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    waitrd && rxrdy |-> !start);

  assert_thr_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_thr_ok |=> !txrdy);
endmodule

bind spi_port_master spi_port_checker u_chk (
  .clk       (clk_i),
  .rst_n     (rst_ni),
  .sck       (sck_o),
  .cpol      (mode_q[16]),
  .busy      (eng_busy),
  .ovr       (ovr),
  .rx_rst    (rx_rst),
  .rd_rhr    (rd_rhr),
  .done      (eng_done),
  .rxrdy     (rxrdy),
  .waitrd    (waitrd),
  .start     (tx_start),
  .wr_thr_ok (wr_thr_ok),
  .txrdy     (txrdy)
);

// File: tb/spi_port_master_tb.sv
module spi_port_master_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, sck, mosi;
  logic        miso = 1'b0;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  spi_port_master u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr),
    .bus_wdata_i(wdata), .bus_rd_i(rd), .bus_rdata_o(rdata),
    .irq_o(irq), .sck_o(sck), .mosi_o(mosi), .miso_i(miso)
  );

  // slave model
  logic       s_pol = 1'b0, s_pha = 1'b0;
  logic [7:0] s_tx = '0, s_rx = '0;
  int         s_idx = 0, sck_edges = 0, last_rise = 0, sck_period = 0;

  always @(posedge sck or negedge sck) begin
    sck_edges++;
    if (sck != s_pol) begin
      if (!s_pha) s_rx = {s_rx[6:0], mosi};
      else if (s_idx < 8) miso = s_tx[7-s_idx];
    end else begin
      if (!s_pha) begin
        s_idx++;
        if (s_idx < 8) miso = s_tx[7-s_idx];
      end else begin
        s_rx = {s_rx[6:0], mosi};
        s_idx++;
      end
    end
  end

  always @(posedge sck) begin
    sck_period = cyc - last_rise;
    last_rise  = cyc;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic wait_rx(input string req);
    logic [31:0] st;
    for (int i = 0; i < 2000; i++) begin
      bus_rd(8'h14, st);
      if (st[0]) return;
    end
    chk(req, 32'h0, 32'h1);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] mk_mode(input logic pol, pha, lp, ck, wt);
    return 32'hCE | (32'(pha) << 8) | (32'(lp) << 15) | (32'(pol) << 16) |
           (32'(ck) << 18) | (32'(wt) << 20);
  endfunction

  task automatic slave_arm(input logic pol, pha, input logic [7:0] tx);
    s_pol = pol; s_pha = pha; s_tx = tx;
    idle(2);
    s_idx = 0; s_rx = '0; miso = tx[7];
  endtask

  // {pol, pha, loop, tx[7:0], slave[7:0]}
  localparam logic [18:0] VEC [8] = '{
    {1'b0, 1'b0, 1'b0, 8'hA5, 8'h3C},
    {1'b0, 1'b1, 1'b0, 8'h5A, 8'hC3},
    {1'b1, 1'b0, 1'b0, 8'h81, 8'h7E},
    {1'b1, 1'b1, 1'b0, 8'hFF, 8'h00},
    {1'b0, 1'b0, 1'b1, 8'h96, 8'h00},
    {1'b1, 1'b1, 1'b1, 8'h01, 8'hFF},
    {1'b0, 1'b1, 1'b0, 8'h00, 8'hFF},
    {1'b1, 1'b0, 1'b1, 8'hE7, 8'h18}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int e0;
    idle(3);
    #1 chk("R1 irq", 32'(irq), 0);
    chk("R1 sck", 32'(sck), 0);
    rst_n = 1'b1;
    bus_rd(8'h14, d); chk("R1 status", d, 0);
    bus_rd(8'h04, d); chk("R1 mode", d, 0);
    bus_rd(8'h20, d); chk("R1 divider", d, 6);
    bus_rd(8'hFC, d); chk("R12 version", d, 32'h0000_0103);

    // R3 mode mask
    bus_wr(8'h04, 32'hFFFF_FFFF);
    bus_rd(8'h04, d); chk("R3 mode mask", d, 32'h0015_81CF);
    bus_wr(8'h04, 0);

    // R2 enables
    bus_wr(8'h00, 32'h50);
    bus_rd(8'h14, d); chk("R2 tx enabled txrdy", d, 32'h2);
    bus_wr(8'h00, 32'hC0);
    bus_rd(8'h14, d); chk("R2 disable wins", d, 32'h0);

    // R7 write ignored while tx disabled
    bus_wr(8'h04, mk_mode(0, 0, 1, 1, 0));
    bus_wr(8'h1C, 32'h55);
    bus_wr(8'h00, 32'h40);
    idle(100);
    bus_rd(8'h14, d); chk("R7 ignored write", d, 32'h2);

    // R3 master gate and R2 tx reset
    bus_wr(8'h04, 32'h0);
    bus_wr(8'h1C, 32'h33);
    idle(100);
    bus_rd(8'h14, d); chk("R3 no master code holds", d, 32'h0);
    bus_wr(8'h00, 32'h08);
    bus_rd(8'h14, d); chk("R2 tx reset empties", d, 32'h2);

    // vector table
    for (int i = 0; i < 8; i++) begin
      logic pol, pha, lp;
      logic [7:0] tx, sl;
      {pol, pha, lp, tx, sl} = VEC[i];
      bus_wr(8'h04, mk_mode(pol, pha, lp, 1, 0));
      slave_arm(pol, pha, sl);
      bus_wr(8'h1C, 32'(tx));
      wait_rx("R8 vec rxrdy");
      bus_rd(8'h18, d);
      chk(lp ? "R6 loopback byte" : "R5 master rx byte", d, 32'(lp ? tx : sl));
      chk("R5 slave rx byte", 32'(s_rx), 32'(tx));
      bus_rd(8'h14, d); chk("R8 rxrdy cleared", d, 32'h2);
    end

    // R4 divider
    bus_wr(8'h20, 3);      bus_rd(8'h20, d); chk("R4 clamp low", d, 6);
    bus_wr(8'h20, 'h1FFFF); bus_rd(8'h20, d); chk("R4 clamp high", d, 32'h10000);
    bus_wr(8'h20, 10);     bus_rd(8'h20, d); chk("R4 in range", d, 10);
    bus_wr(8'h04, mk_mode(0, 0, 1, 1, 0));
    bus_wr(8'h1C, 32'h6C);
    wait_rx("R4 rx");
    chk("R4 sck period", 32'(sck_period), 10);
    bus_rd(8'h18, d); chk("R6 div10 loop", d, 32'h6C);
    bus_wr(8'h20, 3);
    bus_wr(8'h1C, 32'h11);
    wait_rx("R4 rx min");
    chk("R4 sck period min", 32'(sck_period), 6);
    bus_rd(8'h18, d);

    // R9 overrun
    bus_wr(8'h1C, 32'hA1);
    idle(2);
    bus_wr(8'h1C, 32'hB2);
    wait_rx("R9 first");
    idle(100);
    bus_rd(8'h14, d); chk("R9 overrun set", d, 32'h23);
    bus_rd(8'h18, d); chk("R9 newest kept", d, 32'hB2);
    bus_rd(8'h14, d); chk("R9 sticky after read", d, 32'h22);

    // R11 interrupts
    bus_wr(8'h08, 32'h20);
    idle(1); chk("R11 irq ovr", 32'(irq), 1);
    bus_wr(8'h00, 32'h04);
    bus_rd(8'h14, d); chk("R2 rx reset clears ovr", d, 32'h2);
    chk("R11 irq after clear", 32'(irq), 0);
    bus_wr(8'h08, 32'h02);
    idle(1); chk("R11 irq txrdy", 32'(irq), 1);
    bus_wr(8'h0C, 32'h22);
    idle(1); chk("R11 irq masked", 32'(irq), 0);

    // R10 wait-for-read
    bus_wr(8'h04, mk_mode(0, 0, 1, 1, 1));
    bus_wr(8'h1C, 32'hC1);
    wait_rx("R10 first");
    bus_wr(8'h1C, 32'hD2);
    idle(200);
    bus_rd(8'h14, d); chk("R10 second held", d, 32'h1);
    bus_rd(8'h18, d); chk("R10 first byte", d, 32'hC1);
    wait_rx("R10 second");
    bus_rd(8'h14, d); chk("R10 no overrun", d, 32'h3);
    bus_rd(8'h18, d); chk("R10 second byte", d, 32'hD2);

    // R13 clock output off
    bus_wr(8'h04, mk_mode(1, 0, 1, 0, 0));
    idle(2);
    e0 = sck_edges;
    bus_wr(8'h1C, 32'h4B);
    wait_rx("R13 rx");
    chk("R13 no sck edges", 32'(sck_edges - e0), 0);
    chk("R13 sck idle", 32'(sck), 1);
    bus_rd(8'h18, d); chk("R13 loop data", d, 32'h4B);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule